// File: doc/BRIEF.md
# Dual-Channel Timer Bus Front End

This block is the APB slave that sits in front of two independent down-counter channels. It decodes a 4 KB register window and sends one-cycle write strobes to the addressed channel: reload, background reload, control and interrupt clear. The write data travels on a shared bus. The block also selects the readback word from the channel state that the channels present at its inputs. The counting logic is not part of this block. The channels are separate instances that consume the strobes and return their reload value, current count, control byte and raw interrupt flag.

The block builds each channel's interrupt line from that channel's masked status, which is the raw flag gated by the channel's interrupt-enable control bit. It also produces one combined line. A small test facility can take over the interrupt lines: one register switches test mode on, and a second register supplies the level of each line while the mode is active. A fixed set of identification bytes sits at the top of the window.

Every access finishes in its access phase without wait states and never signals an error. Bus reads and writes are the only way software touches the block.

Top module: `dt_apb_frontend`

## Requirements
- R1: A write in the access phase (psel, penable and pwrite all high) to channel sub-offset 0x00 pulses `ch_load_we[c]` for one cycle, with channel c = paddr[5] in the window 0x000–0x03F. During that pulse `ch_wdata` equals `pwdata`.
- R2: Access-phase writes to sub-offsets 0x18, 0x08 and 0x0C of channel c pulse `ch_bgload_we[c]`, `ch_ctrl_we[c]` and `ch_intclr[c]` respectively. At most one strobe in the whole block is high in any cycle.
- R3: Reads of sub-offset 0x00 and of sub-offset 0x18 both return the channel's `ch_reload` word.
- R4: Sub-offset 0x04 reads `ch_value`. Sub-offset 0x08 reads the control byte zero-extended. Sub-offset 0x10 reads the raw flag in bit 0. Sub-offset 0x14 reads the raw flag ANDed with control bit 5 (interrupt enable) in bit 0.
- R5: Offsets that are not mapped read as 0 and ignore writes. This covers sub-offset 0x1C, anything from 0x040 up to 0xEFF, and every offset not listed elsewhere. Writes to sub-offset 0x04 (count) produce no strobe. Reads of sub-offsets 0x0C and 0xF04 return 0.
- R6: Offset 0xF00 is a read/write test-enable register with only bit 0 kept. It resets to 0.
- R7: Offset 0xF04 holds one test level per channel (bit 0 for channel 0, bit 1 for channel 1) and resets to 0. While test-enable is 1, `irq[c]` equals that level.
- R8: While test-enable is 0, `irq[c]` equals the channel's masked status, which is the raw flag AND control bit 5.
- R9: `irq_comb` is the OR of all `irq` bits, taken after the test-mode selection.
- R10: Word reads at 0xFD0 through 0xFFC return the identification bytes 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word in ascending address order.
- R11: `pready` stays 1 and `pslverr` stays 0. No strobe fires during the setup phase.
- R12: An address with paddr[1:0] not equal to 0 is treated as unmapped for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | Byte offset in window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ch_wdata | output | 32 | Write data forwarded to channels |
| ch_load_we | output | 2 | Reload-and-restart strobe per channel |
| ch_bgload_we | output | 2 | Background reload strobe per channel |
| ch_ctrl_we | output | 2 | Control write strobe per channel |
| ch_intclr | output | 2 | Interrupt clear strobe per channel |
| ch_reload | input | 64 | Reload word per channel, channel 0 in low word |
| ch_value | input | 64 | Current count per channel |
| ch_ctrl | input | 16 | Control byte per channel |
| ch_ris | input | 2 | Raw interrupt flag per channel |
| irq | output | 2 | Per-channel interrupt |
| irq_comb | output | 1 | Combined interrupt |

## Verification
The bench targets the following corner cases:
- Channel-select bit. A design that ignored it would strobe or read the wrong channel.
- The unused slot at sub-offset 0x1C, the write-only slots, and misaligned addresses. A sloppy decoder would produce strobes or non-zero data on these.
- Test-mode switch in both directions. A design that missed the override would leave `irq` tracking the channel flags while test mode is on, and would keep the test levels alive after it is turned off.
- Identification block and background-reload readback. An off-by-one index would return the neighbouring byte, and a wrong mux arm would return the count instead of the reload.

// File: rtl/dt_fe_pkg.sv
package dt_fe_pkg;

    localparam int CH_IDX_W   = 4;
    localparam int WIN_SHIFT  = 5;

    localparam logic [11:0] OFS_TEST_EN  = 12'hF00;
    localparam logic [11:0] OFS_TEST_LVL = 12'hF04;
    localparam logic [11:0] OFS_ID_BASE  = 12'hFD0;
    localparam logic [11:0] OFS_ID_LAST  = 12'hFFC;

    typedef enum logic [3:0] {
        K_NONE,
        K_LOAD,
        K_VALUE,
        K_CTRL,
        K_INTCLR,
        K_RIS,
        K_MIS,
        K_BGLOAD,
        K_TEST_EN,
        K_TEST_LVL,
        K_ID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CH_IDX_W-1:0]   ch;
        logic [3:0]            id_idx;
    } dec_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h23;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h1B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

    function automatic reg_kind_e sub_kind(input logic [4:0] sub);
        case (sub)
            5'h00:   sub_kind = K_LOAD;
            5'h04:   sub_kind = K_VALUE;
            5'h08:   sub_kind = K_CTRL;
            5'h0C:   sub_kind = K_INTCLR;
            5'h10:   sub_kind = K_RIS;
            5'h14:   sub_kind = K_MIS;
            5'h18:   sub_kind = K_BGLOAD;
            default: sub_kind = K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dt_fe_decode.sv
module dt_fe_decode
    import dt_fe_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH    = 2
) (
    input  logic [ADDR_W-1:0] paddr,
    output dec_t              dec
);
    localparam int HI_W   = ADDR_W - WIN_SHIFT;
    localparam int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1;

    logic [HI_W-1:0] win_no;
    logic [11:0]     ofs12;
    logic [11:0]     id_ofs;

    assign win_no = paddr[ADDR_W-1:WIN_SHIFT];
    assign ofs12  = 12'(paddr);
    assign id_ofs = ofs12 - OFS_ID_BASE;

    always_comb begin
        dec        = '0;
        dec.kind   = K_NONE;
        if (paddr[1:0] == 2'b00) begin
            if (win_no < HI_W'(NCH)) begin
                dec.kind = sub_kind(paddr[WIN_SHIFT-1:0]);
                dec.ch   = CH_IDX_W'(paddr[WIN_SHIFT +: SEL_W]);
            end else if (ofs12 == OFS_TEST_EN) begin
                dec.kind = K_TEST_EN;
            end else if (ofs12 == OFS_TEST_LVL) begin
                dec.kind = K_TEST_LVL;
            end else if (ofs12 >= OFS_ID_BASE && ofs12 <= OFS_ID_LAST) begin
                dec.kind   = K_ID;
                dec.id_idx = id_ofs[5:2];
            end
        end
    end
endmodule

// File: rtl/dt_fe_testregs.sv
module dt_fe_testregs #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_we,
    input  logic           lvl_we,
    input  logic [31:0]    wdata,
    output logic           test_en,
    output logic [NCH-1:0] test_lvl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            test_en  <= 1'b0;
            test_lvl <= '0;
        end else begin
            if (en_we)  test_en  <= wdata[0];
            if (lvl_we) test_lvl <= wdata[NCH-1:0];
        end
    end
endmodule

// File: rtl/dt_fe_irq.sv
module dt_fe_irq #(
    parameter int NCH       = 2,
    parameter int CTRL_W    = 8,
    parameter int INTEN_BIT = 5
) (
    input  logic                  test_en,
    input  logic [NCH-1:0]        test_lvl,
    input  logic [NCH*CTRL_W-1:0] ch_ctrl,
    input  logic [NCH-1:0]        ch_ris,
    output logic [NCH-1:0]        mis,
    output logic [NCH-1:0]        irq,
    output logic                  irq_comb
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign mis[i] = ch_ris[i] & ch_ctrl[i*CTRL_W + INTEN_BIT];
        assign irq[i] = test_en ? test_lvl[i] : mis[i];
    end
    assign irq_comb = |irq;
endmodule

// File: rtl/dt_fe_rdmux.sv
module dt_fe_rdmux
    import dt_fe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCH    = 2,
    parameter int CTRL_W = 8
) (
    input  dec_t                  dec,
    input  logic [NCH*DATA_W-1:0] ch_reload,
    input  logic [NCH*DATA_W-1:0] ch_value,
    input  logic [NCH*CTRL_W-1:0] ch_ctrl,
    input  logic [NCH-1:0]        ch_ris,
    input  logic [NCH-1:0]        mis,
    input  logic                  test_en,
    output logic [DATA_W-1:0]     rdata
);
    logic [DATA_W-1:0] sel_reload, sel_value;
    logic [CTRL_W-1:0] sel_ctrl;
    logic              sel_ris, sel_mis;

    always_comb begin
        sel_reload = '0;
        sel_value  = '0;
        sel_ctrl   = '0;
        sel_ris    = 1'b0;
        sel_mis    = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (dec.ch == CH_IDX_W'(i)) begin
                sel_reload = ch_reload[i*DATA_W +: DATA_W];
                sel_value  = ch_value[i*DATA_W +: DATA_W];
                sel_ctrl   = ch_ctrl[i*CTRL_W +: CTRL_W];
                sel_ris    = ch_ris[i];
                sel_mis    = mis[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (dec.kind)
            K_LOAD, K_BGLOAD: rdata = sel_reload;
            K_VALUE:          rdata = sel_value;
            K_CTRL:           rdata = DATA_W'(sel_ctrl);
            K_RIS:            rdata = DATA_W'(sel_ris);
            K_MIS:            rdata = DATA_W'(sel_mis);
            K_TEST_EN:        rdata = DATA_W'(test_en);
            K_ID:             rdata = DATA_W'(id_byte(dec.id_idx));
            default:          rdata = '0;
        endcase
    end
endmodule

// File: rtl/dt_apb_frontend.sv
module dt_apb_frontend
    import dt_fe_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NCH       = 2,
    parameter int CTRL_W    = 8,
    parameter int INTEN_BIT = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [ADDR_W-1:0]     paddr,
    input  logic [DATA_W-1:0]     pwdata,
    output logic [DATA_W-1:0]     prdata,
    output logic                  pready,
    output logic                  pslverr,
    output logic [DATA_W-1:0]     ch_wdata,
    output logic [NCH-1:0]        ch_load_we,
    output logic [NCH-1:0]        ch_bgload_we,
    output logic [NCH-1:0]        ch_ctrl_we,
    output logic [NCH-1:0]        ch_intclr,
    input  logic [NCH*DATA_W-1:0] ch_reload,
    input  logic [NCH*DATA_W-1:0] ch_value,
    input  logic [NCH*CTRL_W-1:0] ch_ctrl,
    input  logic [NCH-1:0]        ch_ris,
    output logic [NCH-1:0]        irq,
    output logic                  irq_comb
);
    dec_t              dec;
    logic              wr_acc, rd_sel;
    logic              test_en;
    logic [NCH-1:0]    test_lvl;
    logic [NCH-1:0]    mis;
    logic [DATA_W-1:0] rdata;

    assign wr_acc   = psel & penable & pwrite;
    assign rd_sel   = psel & ~pwrite;
    assign pready   = 1'b1;
    assign pslverr  = 1'b0;
    assign ch_wdata = pwdata;
    assign prdata   = rd_sel ? rdata : '0;

    dt_fe_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
        .paddr (paddr),
        .dec   (dec)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_strobe
        logic hit;
        assign hit             = wr_acc && (dec.ch == CH_IDX_W'(i));
        assign ch_load_we[i]   = hit && (dec.kind == K_LOAD);
        assign ch_bgload_we[i] = hit && (dec.kind == K_BGLOAD);
        assign ch_ctrl_we[i]   = hit && (dec.kind == K_CTRL);
        assign ch_intclr[i]    = hit && (dec.kind == K_INTCLR);
    end

    dt_fe_testregs #(.NCH(NCH)) u_test (
        .clk      (clk),
        .rst      (rst),
        .en_we    (wr_acc && dec.kind == K_TEST_EN),
        .lvl_we   (wr_acc && dec.kind == K_TEST_LVL),
        .wdata    (32'(pwdata)),
        .test_en  (test_en),
        .test_lvl (test_lvl)
    );

    dt_fe_irq #(.NCH(NCH), .CTRL_W(CTRL_W), .INTEN_BIT(INTEN_BIT)) u_irq (
        .test_en  (test_en),
        .test_lvl (test_lvl),
        .ch_ctrl  (ch_ctrl),
        .ch_ris   (ch_ris),
        .mis      (mis),
        .irq      (irq),
        .irq_comb (irq_comb)
    );

    dt_fe_rdmux #(.DATA_W(DATA_W), .NCH(NCH), .CTRL_W(CTRL_W)) u_rd (
        .dec       (dec),
        .ch_reload (ch_reload),
        .ch_value  (ch_value),
        .ch_ctrl   (ch_ctrl),
        .ch_ris    (ch_ris),
        .mis       (mis),
        .test_en   (test_en),
        .rdata     (rdata)
    );
endmodule

// File: rtl/dt_fe_checker.sv
module dt_fe_checker #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NCH       = 2,
    parameter int CTRL_W    = 8,
    parameter int INTEN_BIT = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  psel,
    input logic                  penable,
    input logic                  pwrite,
    input logic [ADDR_W-1:0]     paddr,
    input logic [DATA_W-1:0]     pwdata,
    input logic                  pready,
    input logic                  pslverr,
    input logic [NCH-1:0]        ch_load_we,
    input logic [NCH-1:0]        ch_bgload_we,
    input logic [NCH-1:0]        ch_ctrl_we,
    input logic [NCH-1:0]        ch_intclr,
    input logic [NCH*CTRL_W-1:0] ch_ctrl,
    input logic [NCH-1:0]        ch_ris,
    input logic [NCH-1:0]        irq,
    input logic                  irq_comb
);
    logic           shadow_en;
    logic [NCH-1:0] shadow_lvl;
    logic [NCH-1:0] exp_mis;
    logic           bus_wr;
    logic [4*NCH-1:0] all_strobes;

    assign bus_wr      = psel && penable && pwrite;
    assign all_strobes = {ch_load_we, ch_bgload_we, ch_ctrl_we, ch_intclr};

    always_comb begin
        for (int i = 0; i < NCH; i++)
            exp_mis[i] = ch_ris[i] && ch_ctrl[i*CTRL_W + INTEN_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_en  <= 1'b0;
            shadow_lvl <= '0;
        end else if (bus_wr) begin
            if (32'(paddr) == 32'hF00) shadow_en  <= pwdata[0];
            if (32'(paddr) == 32'hF04) shadow_lvl <= pwdata[NCH-1:0];
        end
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_strobes)); // R2
    AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (|all_strobes) |-> bus_wr); // R11
    AST_NO_WAIT_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr); // R11
    AST_TEST_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        shadow_en |-> (irq == shadow_lvl)); // R7
    AST_NORMAL_IRQ: assert property (@(posedge clk) disable iff (rst)
        !shadow_en |-> (irq == exp_mis)); // R8
    AST_COMBINED: assert property (@(posedge clk) disable iff (rst)
        irq_comb == ($countones(irq) != 0)); // R9
endmodule

bind dt_apb_frontend dt_fe_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .CTRL_W(CTRL_W), .INTEN_BIT(INTEN_BIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .pready       (pready),
    .pslverr      (pslverr),
    .ch_load_we   (ch_load_we),
    .ch_bgload_we (ch_bgload_we),
    .ch_ctrl_we   (ch_ctrl_we),
    .ch_intclr    (ch_intclr),
    .ch_ctrl      (ch_ctrl),
    .ch_ris       (ch_ris),
    .irq          (irq),
    .irq_comb     (irq_comb)
);

// File: tb/tb_dt_apb_frontend.sv
module tb_dt_apb_frontend;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, ch_wdata;
    logic        pready, pslverr, irq_comb;
    logic [1:0]  ch_load_we, ch_bgload_we, ch_ctrl_we, ch_intclr, irq;
    logic [63:0] ch_reload = '0, ch_value = '0;
    logic [15:0] ch_ctrl = '0;
    logic [1:0]  ch_ris = '0;

    int errors = 0, checks = 0;
    logic tb_test_en = 1'b0;
    logic [7:0] s_load, s_bg, s_ctrl, s_clr;
    logic       setup_strobe;
    logic [31:0] s_wdata;

    always #2 clk = ~clk;

    dt_apb_frontend dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .ch_wdata(ch_wdata), .ch_load_we(ch_load_we),
        .ch_bgload_we(ch_bgload_we), .ch_ctrl_we(ch_ctrl_we), .ch_intclr(ch_intclr),
        .ch_reload(ch_reload), .ch_value(ch_value), .ch_ctrl(ch_ctrl),
        .ch_ris(ch_ris), .irq(irq), .irq_comb(irq_comb)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_id(input int i);
        logic [7:0] t [12] = '{8'h04,8'h00,8'h00,8'h00,8'h23,8'hB8,8'h1B,8'h00,8'h0D,8'hF0,8'h05,8'hB1};
        return t[i];
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int c;
        if (a[1:0] != 2'b00) return 32'h0;
        if (a < 12'h040) begin
            c = int'(a[5]);
            case (a[4:0])
                5'h00, 5'h18: return ch_reload[c*32 +: 32];
                5'h04: return ch_value[c*32 +: 32];
                5'h08: return {24'h0, ch_ctrl[c*8 +: 8]};
                5'h10: return {31'h0, ch_ris[c]};
                5'h14: return {31'h0, ch_ris[c] & ch_ctrl[c*8+5]};
                default: return 32'h0;
            endcase
        end
        if (a == 12'hF00) return {31'h0, tb_test_en};
        if (a >= 12'hFD0) return {24'h0, exp_id(int'((a - 12'hFD0) >> 2))};
        return 32'h0;
    endfunction

    function automatic logic [1:0] exp_mis();
        return {ch_ris[1] & ch_ctrl[13], ch_ris[0] & ch_ctrl[5]};
    endfunction

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        #1 setup_strobe = |{ch_load_we, ch_bgload_we, ch_ctrl_we, ch_intclr};
        @(negedge clk);
        penable = 1;
        #1;
        s_load = 8'(ch_load_we); s_bg = 8'(ch_bgload_we);
        s_ctrl = 8'(ch_ctrl_we); s_clr = 8'(ch_intclr); s_wdata = ch_wdata;
        chk(pready && !pslverr, "R11 ready/err", {30'h0, pready, pslverr}, 32'h2);
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic wr_expect(input logic [11:0] a, input logic [31:0] d,
                             input logic [7:0] el, eb, ec, ei, input string req);
        apb_wr(a, d);
        chk(!setup_strobe, {req, " setup phase quiet (R11)"}, {31'h0, setup_strobe}, 32'h0);
        chk({s_load, s_bg, s_ctrl, s_clr} == {el, eb, ec, ei}, req,
            {s_load, s_bg, s_ctrl, s_clr}, {el, eb, ec, ei});
        if ((el | eb | ec | ei) != 0)
            chk(s_wdata == d, {req, " wdata"}, s_wdata, d);
    endtask

    task automatic rd_expect(input logic [11:0] a, input string req);
        logic [31:0] got, ex;
        ex = exp_read(a);
        apb_rd(a, got);
        chk(got == ex, req, got, ex);
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // reset state (R6, R7, R8, R11)
        #1 chk(irq == 2'b00 && !irq_comb, "R8 reset irq", {29'h0, irq, irq_comb}, 32'h0);
        chk(pready && !pslverr, "R11 reset ready", {30'h0, pready, pslverr}, 32'h2);
        rd_expect(12'hF00, "R6 reset test-enable");

        // R1/R2 strobes per channel
        wr_expect(12'h000, 32'hDEAD_0001, 8'h1, 0, 0, 0, "R1 load ch0");
        wr_expect(12'h020, 32'h1234_5678, 8'h2, 0, 0, 0, "R1 load ch1");
        wr_expect(12'h018, 32'h0000_00AA, 0, 8'h1, 0, 0, "R2 bgload ch0");
        wr_expect(12'h038, 32'h0000_00BB, 0, 8'h2, 0, 0, "R2 bgload ch1");
        wr_expect(12'h008, 32'h0000_00E1, 0, 0, 8'h1, 0, "R2 ctrl ch0");
        wr_expect(12'h028, 32'h0000_0022, 0, 0, 8'h2, 0, "R2 ctrl ch1");
        wr_expect(12'h00C, 32'h1, 0, 0, 0, 8'h1, "R2 intclr ch0");
        wr_expect(12'h02C, 32'h1, 0, 0, 0, 8'h2, "R2 intclr ch1");
        // R5 / R12 no-effect writes
        wr_expect(12'h004, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5 value write ignored");
        wr_expect(12'h01C, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5 sub 0x1C ignored");
        wr_expect(12'h040, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5 above windows ignored");
        wr_expect(12'h001, 32'hFFFF_FFFF, 0, 0, 0, 0, "R12 misaligned load ignored");
        wr_expect(12'hF01, 32'h1, 0, 0, 0, 0, "R12 misaligned test-enable ignored");
        rd_expect(12'hF00, "R12 test-enable untouched");

        // R3/R4 readback with distinct channel data
        ch_reload = {32'hCAFE_0002, 32'hBEEF_0001};
        ch_value  = {32'h0000_1111, 32'h0000_2222};
        ch_ctrl   = {8'hE0, 8'h41};
        ch_ris    = 2'b11;
        rd_expect(12'h000, "R3 load ch0");
        rd_expect(12'h018, "R3 bgload ch0");
        rd_expect(12'h038, "R3 bgload ch1");
        rd_expect(12'h024, "R4 value ch1");
        rd_expect(12'h008, "R4 ctrl ch0");
        rd_expect(12'h030, "R4 ris ch1");
        rd_expect(12'h014, "R4 mis ch0");
        rd_expect(12'h034, "R4 mis ch1");
        rd_expect(12'h00C, "R5 intclr reads zero");
        rd_expect(12'h01C, "R5 sub 0x1C reads zero");
        rd_expect(12'h804, "R5 hole reads zero");
        rd_expect(12'hF04, "R5 test level reads zero");
        rd_expect(12'h002, "R12 misaligned read zero");

        // R8 normal irq follows masked status
        @(negedge clk);
        ch_ctrl = {8'h00, 8'h20}; ch_ris = 2'b01;
        #1 chk(irq == 2'b01, "R8 mis ch0 only", {30'h0, irq}, 32'h1);
        chk(irq_comb == 1'b1, "R9 comb high", {31'h0, irq_comb}, 32'h1);
        ch_ris = 2'b10;
        #1 chk(irq == 2'b00 && !irq_comb, "R8 masked ch1", {29'h0, irq, irq_comb}, 32'h0);

        // R6/R7 test mode override
        apb_wr(12'hF04, 32'h0000_0002);
        apb_wr(12'hF00, 32'hFFFF_FFFF); tb_test_en = 1'b1;
        rd_expect(12'hF00, "R6 test-enable bit0 only");
        #1 chk(irq == 2'b10, "R7 test lvl drives irq", {30'h0, irq}, 32'h2);
        chk(irq_comb, "R9 comb in test mode", {31'h0, irq_comb}, 32'h1);
        ch_ris = 2'b11; ch_ctrl = 16'hFFFF;
        #1 chk(irq == 2'b10, "R7 ignores channel flags", {30'h0, irq}, 32'h2);
        apb_wr(12'hF04, 32'h0);
        #1 chk(irq == 2'b00 && !irq_comb, "R7 test lvl zero", {29'h0, irq, irq_comb}, 32'h0);
        apb_wr(12'hF00, 32'h0); tb_test_en = 1'b0;
        #1 chk(irq == 2'b11, "R8 back to masked status", {30'h0, irq}, 32'h3);

        // R10 identification block
        for (int i = 0; i < 12; i++)
            rd_expect(12'(12'hFD0 + 4 * i), "R10 id byte");

        // random readback mixed over channel windows and the whole map
        for (int n = 0; n < 300; n++) begin
            logic [11:0] a;
            ch_reload = {$urandom, $urandom};
            ch_value  = {$urandom, $urandom};
            ch_ctrl   = 16'($urandom);
            ch_ris    = 2'($urandom);
            a = (n % 2 == 0) ? {6'h0, 6'($urandom) & 6'h3C} : 12'($urandom);
            if (n % 7 == 0) a = a | 12'h1;
            rd_expect(a, "R4 random readback");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule